// File: doc/BRIEF.md
# I2C Engine Ownership Arbiter

This block decides who drives a single shared I2C master engine: a software client that issues register-level "go" requests, or an autonomous hardware requester that raises a level request for as long as it needs the bus. Only one owner holds the engine at a time. The block reports the owner on a two-bit status port and drives one grant line per owner. It also drives a one-cycle start strobe whenever a software transfer is launched. The engine itself sits outside and returns a byte-boundary pulse and a transfer-done pulse.

Software can run at normal priority, where hardware waits for the running software transfer to finish. It can also run at high priority, where hardware cuts in at the next byte boundary. A job cut short this way can be restarted automatically when hardware lets go. A no-queue option makes the block refuse a software go that arrives while hardware holds the engine, instead of keeping it pending. Software gives the engine back with a release strobe or a status reset. A soft-reset request reaches the engine only while software owns it.

Top module: `i2c_own_arbiter`

## Requirements
- R1: After reset the status reads 0 (idle), and no grant, start, reject or soft-reset output is high. Status values: 0 idle, 1 software owner, 2 hardware owner.
- R2: A software go seen while idle, with no hardware request, makes the status 1 one cycle later. In that same cycle it raises the software grant and a start pulse that lasts exactly one cycle.
- R3: At most one grant is high in any cycle. The software grant is high exactly when the status is 1, and the hardware grant exactly when the status is 2.
- R4: With priority 0 (normal), a hardware request arriving during a software transfer leaves the status at 1 until the transfer-done pulse. The status becomes 2 in the cycle after that pulse.
- R5: With priority 1 (high), a hardware request during a software transfer moves the status to 2 in the cycle after the next byte-boundary pulse, without waiting for the transfer to finish.
- R6: When hardware drops its request after pre-empting software, the status returns to 1 with a new start pulse if restart is enabled. If restart is disabled, it returns to 0.
- R7: A software go seen while the status is 2 raises the reject output for exactly one cycle, in the next cycle, if no-queue is set, and the go is discarded. If no-queue is clear, the go is held and granted, with a start pulse, when hardware releases.
- R8: The release strobe returns the status from 1 to 0 when no transfer is in flight. While a transfer is in flight it has no effect.
- R9: The status-reset input returns the status from 1 to 0 when no transfer is in flight. It has no effect while a transfer is in flight or while the status is 2.
- R10: A soft-reset request produces a one-cycle soft-reset output in the next cycle only if the status was 1. Otherwise it is dropped.
- R11: From idle, a hardware request wins over a simultaneous software go. The status becomes 2, and the software go is held pending if no-queue is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swGo | input | 1 | Software transfer request strobe |
| swRelease | input | 1 | Software release strobe |
| prioHigh | input | 1 | Software priority: 0 normal, 1 high |
| noQueue | input | 1 | Reject software go while hardware owns |
| restartEn | input | 1 | Resume pre-empted software job |
| statusRst | input | 1 | Return status to idle when nothing in flight |
| softRstReq | input | 1 | Soft reset request for the engine |
| hwReq | input | 1 | Hardware requester level request |
| engByteEnd | input | 1 | Engine byte boundary pulse |
| engDone | input | 1 | Engine transfer complete pulse |
| ownStatus | output | 2 | Current owner: 0 idle, 1 software, 2 hardware |
| swGrant | output | 1 | Engine granted to software |
| hwGrant | output | 1 | Engine granted to hardware |
| engStart | output | 1 | One-cycle start of a software transfer |
| busyReject | output | 1 | One-cycle pulse for a refused software go |
| softRstOut | output | 1 | One-cycle soft reset toward the engine |

## Verification
Directed sequences cover the arbitration paths one at a time. A hardware request arrives mid-transfer under each priority, which tells waiting for done apart from cutting in at a byte boundary. Hardware then releases with restart on and off, which tells a resumed job apart from a dropped one. A go arrives during hardware ownership with no-queue set and clear, which tells rejection apart from queuing. Release and status-reset strobes are placed inside and outside a transfer. A seeded random phase then drives all inputs freely and checks grant exclusivity against the status, and it checks each reject and soft-reset pulse against the inputs and status of the cycle before.

// File: rtl/i2c_own_pkg.sv
package i2c_own_pkg;
  localparam int STAT_W = 2;

  typedef enum logic [STAT_W-1:0] {
    OWN_IDLE = 2'd0,
    OWN_SW   = 2'd1,
    OWN_HW   = 2'd2
  } own_e;

  typedef struct packed {
    logic grantSw;
    logic grantHw;
    logic start;
    logic setPend;
    logic clrPend;
    logic setSusp;
    logic clrSusp;
    logic reject;
    logic softRst;
  } strobe_t;
endpackage

// File: rtl/i2c_own_ctrl.sv
module i2c_own_ctrl
  import i2c_own_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    swGo,
  input  logic    swRelease,
  input  logic    prioHigh,
  input  logic    noQueue,
  input  logic    restartEn,
  input  logic    statusRst,
  input  logic    softRstReq,
  input  logic    hwReq,
  input  logic    engByteEnd,
  input  logic    engDone,
  input  logic    pending,
  input  logic    suspended,
  output own_e    owner,
  output strobe_t strobe
);
  own_e ownerNext;
  logic inFlight, inFlightNext;
  logic goQueueable;

  assign goQueueable = swGo && !noQueue;

  always_comb begin
    ownerNext    = owner;
    inFlightNext = inFlight;
    strobe       = '0;
    strobe.reject  = swGo && (owner == OWN_HW) && noQueue;
    strobe.softRst = softRstReq && (owner == OWN_SW);
    unique case (owner)
      OWN_IDLE: begin
        if (hwReq) begin
          ownerNext = OWN_HW;
          strobe.setPend = goQueueable;
        end else if (swGo || pending) begin
          ownerNext      = OWN_SW;
          inFlightNext   = 1'b1;
          strobe.start   = 1'b1;
          strobe.clrPend = 1'b1;
        end
      end
      OWN_SW: begin
        if (inFlight) begin
          if (engDone) begin
            inFlightNext = 1'b0;
            if (hwReq) ownerNext = OWN_HW;
          end else if (hwReq && prioHigh && engByteEnd) begin
            ownerNext      = OWN_HW;
            inFlightNext   = 1'b0;
            strobe.setSusp = 1'b1;
          end
        end else if (hwReq) begin
          ownerNext = OWN_HW;
        end else if (swGo || pending) begin
          inFlightNext   = 1'b1;
          strobe.start   = 1'b1;
          strobe.clrPend = 1'b1;
        end else if (swRelease || statusRst) begin
          ownerNext = OWN_IDLE;
        end
      end
      OWN_HW: begin
        strobe.setPend = goQueueable;
        if (!hwReq) begin
          strobe.clrSusp = 1'b1;
          if ((suspended && restartEn) || pending || goQueueable) begin
            ownerNext      = OWN_SW;
            inFlightNext   = 1'b1;
            strobe.start   = 1'b1;
            strobe.clrPend = !(suspended && restartEn);
          end else begin
            ownerNext = OWN_IDLE;
          end
        end
      end
      default: ownerNext = OWN_IDLE;
    endcase
    strobe.grantSw = (ownerNext == OWN_SW);
    strobe.grantHw = (ownerNext == OWN_HW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner    <= OWN_IDLE;
      inFlight <= 1'b0;
    end else begin
      owner    <= ownerNext;
      inFlight <= inFlightNext;
    end
  end

  // R4: normal priority never hands a running transfer to hardware before done
  p_norm_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_SW && inFlight && !prioHigh && !engDone) |=> (owner != OWN_HW));

  // R8: release ignored while a transfer is in flight
  p_release_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_SW && inFlight && swRelease && !engDone && !engByteEnd) |=> (owner == OWN_SW));

  // R2: a software transfer is only in flight under software ownership
  p_flight_owner_r2: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> (owner == OWN_SW));
endmodule

// File: rtl/i2c_own_dp.sv
module i2c_own_dp
  import i2c_own_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  output logic    pending,
  output logic    suspended,
  output logic    swGrant,
  output logic    hwGrant,
  output logic    engStart,
  output logic    busyReject,
  output logic    softRstOut
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending    <= 1'b0;
      suspended  <= 1'b0;
      swGrant    <= 1'b0;
      hwGrant    <= 1'b0;
      engStart   <= 1'b0;
      busyReject <= 1'b0;
      softRstOut <= 1'b0;
    end else begin
      if (strobe.clrPend)      pending <= 1'b0;
      else if (strobe.setPend) pending <= 1'b1;
      if (strobe.clrSusp)      suspended <= 1'b0;
      else if (strobe.setSusp) suspended <= 1'b1;
      swGrant    <= strobe.grantSw;
      hwGrant    <= strobe.grantHw;
      engStart   <= strobe.start;
      busyReject <= strobe.reject;
      softRstOut <= strobe.softRst;
    end
  end

  // R3: grants never overlap
  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(swGrant && hwGrant));

  // R2: a start pulse only accompanies the software grant
  p_start_sw_r2: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> swGrant);

  // R2: start is a single-cycle pulse
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);
endmodule

// File: rtl/i2c_own_arbiter.sv
module i2c_own_arbiter
  import i2c_own_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swGo,
  input  logic              swRelease,
  input  logic              prioHigh,
  input  logic              noQueue,
  input  logic              restartEn,
  input  logic              statusRst,
  input  logic              softRstReq,
  input  logic              hwReq,
  input  logic              engByteEnd,
  input  logic              engDone,
  output logic [STAT_W-1:0] ownStatus,
  output logic              swGrant,
  output logic              hwGrant,
  output logic              engStart,
  output logic              busyReject,
  output logic              softRstOut
);
  own_e    owner;
  strobe_t strobe;
  logic    pending, suspended;

  i2c_own_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .swGo(swGo), .swRelease(swRelease),
    .prioHigh(prioHigh), .noQueue(noQueue), .restartEn(restartEn),
    .statusRst(statusRst), .softRstReq(softRstReq), .hwReq(hwReq),
    .engByteEnd(engByteEnd), .engDone(engDone), .pending(pending),
    .suspended(suspended), .owner(owner), .strobe(strobe)
  );

  i2c_own_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pending(pending),
    .suspended(suspended), .swGrant(swGrant), .hwGrant(hwGrant),
    .engStart(engStart), .busyReject(busyReject), .softRstOut(softRstOut)
  );

  assign ownStatus = owner;

  // R7: a reject pulse only follows a go seen under hardware ownership with no-queue
  p_reject_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyReject |-> ($past(ownStatus) == OWN_HW && $past(noQueue) && $past(swGo)));

  // R10: soft reset passes only from software ownership
  p_softrst_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    softRstOut |-> ($past(ownStatus) == OWN_SW && $past(softRstReq)));
endmodule

// File: tb/i2c_own_arbiter_test.sv
module i2c_own_arbiter_test;
  logic clk = 1'b0;
  logic rstN;
  logic swGo, swRelease, prioHigh, noQueue, restartEn, statusRst;
  logic softRstReq, hwReq, engByteEnd, engDone;
  logic [1:0] ownStatus;
  logic swGrant, hwGrant, engStart, busyReject, softRstOut;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_own_arbiter uut (
    .clk(clk), .rstN(rstN), .swGo(swGo), .swRelease(swRelease),
    .prioHigh(prioHigh), .noQueue(noQueue), .restartEn(restartEn),
    .statusRst(statusRst), .softRstReq(softRstReq), .hwReq(hwReq),
    .engByteEnd(engByteEnd), .engDone(engDone), .ownStatus(ownStatus),
    .swGrant(swGrant), .hwGrant(hwGrant), .engStart(engStart),
    .busyReject(busyReject), .softRstOut(softRstOut)
  );

  function automatic bit grantsMatch(logic [1:0] st, logic sg, logic hg);
    return (sg == (st == 2'd1)) && (hg == (st == 2'd2)) && !(sg && hg);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkStat(input string req, input int exp);
    chk(ownStatus == exp, req, ownStatus, exp);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    swGo = 0; swRelease = 0; prioHigh = 0; noQueue = 0; restartEn = 0;
    statusRst = 0; softRstReq = 0; hwReq = 0; engByteEnd = 0; engDone = 0;
  endtask

  task automatic doReset();
    clearIn();
    rstN = 0;
    step(); step();
    rstN = 1;
    step();
  endtask

  task automatic startSw();
    swGo = 1; step(); swGo = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] prevStat;
    logic prevGo, prevNoQ, prevSoft;
    doReset();
    // R1 reset state
    chkStat("R1 status", 0);
    chk(!swGrant && !hwGrant && !engStart && !busyReject && !softRstOut, "R1 outputs",
        {swGrant, hwGrant, engStart, busyReject, softRstOut}, 0);

    // R2 go from idle
    swGo = 1; step(); swGo = 0;
    chkStat("R2 status", 1);
    chk(swGrant && engStart, "R2 grant+start", {swGrant, engStart}, 3);
    step();
    chk(!engStart, "R2 start pulse width", engStart, 0);
    // R8 release ignored during transfer
    swRelease = 1; step(); swRelease = 0;
    chkStat("R8 release in flight", 1);
    engDone = 1; step(); engDone = 0;
    softRstReq = 1; step(); softRstReq = 0;
    chk(softRstOut, "R10 soft reset from sw", softRstOut, 1);
    swRelease = 1; step(); swRelease = 0;
    chkStat("R8 release idle", 0);
    softRstReq = 1; step(); softRstReq = 0;
    chk(!softRstOut, "R10 soft reset dropped when idle", softRstOut, 0);

    // R4 normal priority waits for done
    doReset();
    startSw();
    hwReq = 1; engByteEnd = 1; step(); engByteEnd = 0;
    chkStat("R4 waits at byte end", 1);
    step();
    chkStat("R4 still waits", 1);
    engDone = 1; step(); engDone = 0;
    chkStat("R4 after done", 2);
    chk(hwGrant && !swGrant, "R3 hw grant", {swGrant, hwGrant}, 1);
    // R7 reject with no-queue
    noQueue = 1; swGo = 1; step(); swGo = 0;
    chk(busyReject, "R7 reject pulse", busyReject, 1);
    step();
    chk(!busyReject, "R7 reject one cycle", busyReject, 0);
    softRstReq = 1; step(); softRstReq = 0;
    chk(!softRstOut, "R10 soft reset dropped under hw", softRstOut, 0);
    statusRst = 1; step(); statusRst = 0;
    chkStat("R9 status reset ignored under hw", 2);
    hwReq = 0; step();
    chkStat("R7 rejected go not queued", 0);

    // R5/R6 high priority with restart
    doReset();
    prioHigh = 1; restartEn = 1;
    startSw();
    hwReq = 1; step();
    chkStat("R5 waits for byte boundary", 1);
    engByteEnd = 1; step(); engByteEnd = 0;
    chkStat("R5 preempt", 2);
    hwReq = 0; step();
    chkStat("R6 restart resumes", 1);
    chk(engStart, "R6 restart start pulse", engStart, 1);

    // R6 without restart
    doReset();
    prioHigh = 1; restartEn = 0;
    startSw();
    hwReq = 1; engByteEnd = 1; step(); engByteEnd = 0;
    chkStat("R5 preempt no restart", 2);
    hwReq = 0; step();
    chkStat("R6 no restart goes idle", 0);

    // R7 queued go, R11 hw from idle
    doReset();
    hwReq = 1; step();
    chkStat("R11 hw from idle", 2);
    swGo = 1; step(); swGo = 0;
    chk(!busyReject, "R7 no reject when queueing", busyReject, 0);
    hwReq = 0; step();
    chkStat("R7 queued go granted", 1);
    chk(engStart, "R7 queued start", engStart, 1);

    // R11 tie
    doReset();
    hwReq = 1; swGo = 1; step(); swGo = 0;
    chkStat("R11 tie to hw", 2);
    hwReq = 0; step();
    chkStat("R11 pending go served", 1);

    // R9 status reset
    doReset();
    startSw();
    statusRst = 1; step(); statusRst = 0;
    chkStat("R9 ignored in flight", 1);
    engDone = 1; step(); engDone = 0;
    statusRst = 1; step(); statusRst = 0;
    chkStat("R9 returns idle", 0);

    // random phase: R3, R7, R10
    doReset();
    void'($urandom(32'd2024));
    prevStat = ownStatus; prevGo = 0; prevNoQ = 0; prevSoft = 0;
    for (int i = 0; i < 3000; i++) begin
      swGo       = ($urandom % 6) == 0;
      swRelease  = ($urandom % 8) == 0;
      prioHigh   = $urandom % 2;
      noQueue    = $urandom % 2;
      restartEn  = $urandom % 2;
      statusRst  = ($urandom % 16) == 0;
      softRstReq = ($urandom % 8) == 0;
      hwReq      = ($urandom % 4) != 0 ? hwReq : ~hwReq;
      engByteEnd = ($urandom % 3) == 0;
      engDone    = ($urandom % 7) == 0;
      prevStat = ownStatus; prevGo = swGo; prevNoQ = noQueue; prevSoft = softRstReq;
      step();
      chk(grantsMatch(ownStatus, swGrant, hwGrant), "R3 random grants",
          {swGrant, hwGrant}, ownStatus);
      chk(busyReject == (prevGo && prevNoQ && prevStat == 2), "R7 random reject",
          busyReject, int'(prevGo && prevNoQ && prevStat == 2));
      chk(softRstOut == (prevSoft && prevStat == 1), "R10 random soft reset",
          softRstOut, int'(prevSoft && prevStat == 1));
      chk(!engStart || swGrant, "R2 random start", engStart, 0);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule